// File: doc/BRIEF.md
# Auto-Focus Partial-Frame Window Sequencer

This block times a shortened frame used when a camera hunts for focus. Only a band of the picture is read out. Each frame starts with a pulse. The block then runs a lead-in. Next comes a fast shift phase that throws away a programmable number of lines at the top. A window follows, in which source lines are presented one per line period. A fast sweep then empties everything below the window, and the block rests until the next frame pulse.

Two mode inputs select the window length. One picks the fast or the faster focus rate, and the other picks the 60 Hz or 50 Hz television timing. The skip count sets where the window starts. The first two lines of every window come from the region the shift disturbed. They are presented but flagged as not valid.

A line period is `LINE_CLKS` clock cycles. "Slot k" means line period k, counted from the clock edge that samples the frame pulse.

Top module: `af_window_ctrl`

## Requirements
- R1: While `rst` is high and afterwards until the first accepted `sof`, `in_shift`, `in_window`, `in_sweep` and `line_valid` are 0 and `src_line` is 0.
- R2: After `sof`, the block first runs a lead-in with no phase flag raised. The lead-in lasts 11 slots when `af2_sel`=0 and 15 slots when `af2_sel`=1. `in_shift` is then high for exactly 13 slots.
- R3: The window starts directly after the shift, with `src_line` = skip+1 and then skip+2. `line_valid` is 0 for those two slots. `src_line` rises by exactly one per slot while `in_window` is high.
- R4: The first valid line is skip+3 and appears in slot 26 when `af2_sel`=0 and in slot 30 when `af2_sel`=1. Every later window line is valid.
- R5: The last window line is skip+108 (`af2_sel`=0, `pal_sel`=0), skip+134 (0,1), skip+38 (1,0) or skip+47 (1,1).
- R6: The window never presents a line above 258. If the mode offset would pass 258, the last line is 258.
- R7: `in_sweep` follows the window directly and lasts 7 slots when `af2_sel`=0 and 11 slots when `af2_sel`=1. After the sweep all flags are 0 and `src_line` is 0 until the next `sof`.
- R8: `shift_cnt`, `af2_sel` and `pal_sel` are sampled only at the edge where `sof` is high. Changing them later in the frame does not alter that frame's phases or lines.
- R9: A `sof` seen in any phase restarts the sequence from the lead-in with freshly sampled settings.
- R10: At most one of `in_shift`, `in_window`, `in_sweep` is high. `line_valid` is high only while `in_window` is high. Outside the window `src_line` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start-of-frame pulse |
| shift_cnt | input | 8 | Number of top lines to discard (0 to 255) |
| af2_sel | input | 1 | 0: 60/50 fps focus mode, 1: 120/100 fps focus mode |
| pal_sel | input | 1 | 0: 60 Hz timing, 1: 50 Hz timing |
| in_shift | output | 1 | Fast top-shift phase active |
| in_window | output | 1 | Output window active |
| in_sweep | output | 1 | Bottom sweep phase active |
| line_valid | output | 1 | Current window line is usable |
| src_line | output | 9 | Source line presented in the window, 0 outside |

## Verification
The bench builds the block with `LINE_CLKS` = 4, so that a full frame takes only a few hundred cycles. Every slot boundary of every phase can then be compared cycle by cycle. This short line period makes it practical to run all four mode combinations many times. It also reaches the skip extremes 0 and 255 and the values on both sides of the 258 clip point. Each frame is also restarted in the middle of its window and has its settings changed after the frame pulse.

// File: rtl/af_win_pkg.sv
package af_win_pkg;

    localparam int SKIP_W      = 8;
    localparam int LINE_W      = 9;
    localparam int SLOT_W      = 4;
    localparam int MAX_LINE    = 258;
    localparam int SHIFT_SLOTS = 13;
    localparam int MASKED      = 2;
    localparam int FAST_OUT    = 26;
    localparam int FASTER_OUT  = 30;
    localparam int FAST_SWEEP  = 7;
    localparam int FASTER_SWEEP = 11;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SHIFT,
        PH_WIN,
        PH_SWEEP
    } phase_e;

    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic              af2;
        logic              pal;
    } frame_cfg_t;

    function automatic logic [SLOT_W-1:0] lead_slots(logic af2);
        int s;
        s = (af2 ? FASTER_OUT : FAST_OUT) - MASKED - SHIFT_SLOTS;
        return SLOT_W'(s);
    endfunction

    function automatic logic [SLOT_W-1:0] sweep_slots(logic af2);
        return af2 ? SLOT_W'(FASTER_SWEEP) : SLOT_W'(FAST_SWEEP);
    endfunction

    function automatic logic [LINE_W-1:0] win_last(frame_cfg_t c);
        logic [LINE_W:0] span;
        logic [LINE_W:0] sum;
        if (c.af2)
            span = c.pal ? (LINE_W+1)'(47) : (LINE_W+1)'(38);
        else
            span = c.pal ? (LINE_W+1)'(134) : (LINE_W+1)'(108);
        sum = (LINE_W+1)'(c.skip) + span;
        if (sum > (LINE_W+1)'(MAX_LINE))
            return LINE_W'(MAX_LINE);
        return sum[LINE_W-1:0];
    endfunction

endpackage

// File: rtl/af_line_timer.sv
module af_line_timer #(
    parameter int LINE_CLKS = 2288
) (
    input  logic clk,
    input  logic rst,
    input  logic sof,
    output logic tick
);
    localparam int CNT_W = (LINE_CLKS > 1) ? $clog2(LINE_CLKS) : 1;

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(LINE_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || sof || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/af_phase_seq.sv
module af_phase_seq
    import af_win_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sof,
    input  logic   tick,
    input  logic   af2,
    input  logic   win_done,
    output phase_e phase,
    output logic   win_enter
);
    logic [SLOT_W-1:0] slot;

    assign win_enter = tick && !sof && (phase == PH_SHIFT)
                       && (slot == SLOT_W'(SHIFT_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            slot  <= '0;
        end else if (sof) begin
            phase <= PH_LEAD;
            slot  <= '0;
        end else if (tick) begin
            case (phase)
                PH_LEAD: begin
                    if (slot == lead_slots(af2) - 1'b1) begin
                        phase <= PH_SHIFT;
                        slot  <= '0;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (win_enter) begin
                        phase <= PH_WIN;
                        slot  <= '0;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                PH_WIN: begin
                    if (win_done) begin
                        phase <= PH_SWEEP;
                        slot  <= '0;
                    end
                end
                PH_SWEEP: begin
                    if (slot == sweep_slots(af2) - 1'b1) begin
                        phase <= PH_IDLE;
                        slot  <= '0;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    slot  <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/af_line_track.sv
module af_line_track
    import af_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              tick,
    input  phase_e            phase,
    input  logic              win_enter,
    input  frame_cfg_t        cfg,
    output logic [LINE_W-1:0] cur_line,
    output logic              win_done,
    output logic              valid
);
    logic [LINE_W-1:0] first_good;

    assign first_good = LINE_W'(cfg.skip) + LINE_W'(MASKED + 1);
    assign win_done   = (phase == PH_WIN) && (cur_line == win_last(cfg));
    assign valid      = (phase == PH_WIN) && (cur_line >= first_good);

    always_ff @(posedge clk) begin
        if (rst || sof)
            cur_line <= '0;
        else if (win_enter)
            cur_line <= LINE_W'(cfg.skip) + 1'b1;
        else if (tick && (phase == PH_WIN) && !win_done)
            cur_line <= cur_line + 1'b1;
    end
endmodule

// File: rtl/af_window_ctrl.sv
module af_window_ctrl
    import af_win_pkg::*;
#(
    parameter int LINE_CLKS = 2288
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic [7:0] shift_cnt,
    input  logic       af2_sel,
    input  logic       pal_sel,
    output logic       in_shift,
    output logic       in_window,
    output logic       in_sweep,
    output logic       line_valid,
    output logic [8:0] src_line
);
    frame_cfg_t        cfg;
    phase_e            phase;
    logic              tick;
    logic              win_enter;
    logic              win_done;
    logic              valid;
    logic [LINE_W-1:0] cur_line;

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (sof)
            cfg <= '{skip: shift_cnt, af2: af2_sel, pal: pal_sel};
    end

    af_line_timer #(.LINE_CLKS(LINE_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .sof  (sof),
        .tick (tick)
    );

    af_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .tick      (tick),
        .af2       (cfg.af2),
        .win_done  (win_done),
        .phase     (phase),
        .win_enter (win_enter)
    );

    af_line_track u_track (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .tick      (tick),
        .phase     (phase),
        .win_enter (win_enter),
        .cfg       (cfg),
        .cur_line  (cur_line),
        .win_done  (win_done),
        .valid     (valid)
    );

    assign in_shift   = (phase == PH_SHIFT);
    assign in_window  = (phase == PH_WIN);
    assign in_sweep   = (phase == PH_SWEEP);
    assign line_valid = valid;
    assign src_line   = in_window ? cur_line : '0;
endmodule

// File: rtl/af_window_chk.sv
module af_window_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_shift,
    input logic       in_window,
    input logic       in_sweep,
    input logic       line_valid,
    input logic [8:0] src_line
);
    p_one_phase_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_shift, in_window, in_sweep}));

    p_valid_in_win_r10: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> in_window);

    p_line_zero_out_r10: assert property (@(posedge clk) disable iff (rst)
        !in_window |-> (src_line == 9'd0));

    p_clip_r6: assert property (@(posedge clk) disable iff (rst)
        in_window |-> (src_line <= 9'd258));

    p_win_after_shift_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(in_window) |-> $past(in_shift));

    p_first_masked_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(in_window) |-> !line_valid);

    p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
        (in_window && $past(in_window) && (src_line != $past(src_line)))
            |-> (src_line == $past(src_line) + 9'd1));

    p_sweep_after_win_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sweep) |-> $past(in_window));
endmodule

bind af_window_ctrl af_window_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_shift   (in_shift),
    .in_window  (in_window),
    .in_sweep   (in_sweep),
    .line_valid (line_valid),
    .src_line   (src_line)
);

// File: tb/af_window_ctrl_bench.sv
`timescale 1ns/1ps
module af_window_ctrl_bench;
    localparam int L = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sof = 1'b0;
    logic [7:0] shift_cnt = '0;
    logic       af2_sel = 1'b0;
    logic       pal_sel = 1'b0;
    logic       in_shift, in_window, in_sweep, line_valid;
    logic [8:0] src_line;

    always #2.5 clk = ~clk;

    af_window_ctrl #(.LINE_CLKS(L)) u_af_window_ctrl (
        .clk(clk), .rst(rst), .sof(sof), .shift_cnt(shift_cnt),
        .af2_sel(af2_sel), .pal_sel(pal_sel), .in_shift(in_shift),
        .in_window(in_window), .in_sweep(in_sweep),
        .line_valid(line_valid), .src_line(src_line)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    bit m_active = 0;
    int m_n = 0;
    int m_skip = 0;
    bit m_af2 = 0;
    bit m_pal = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int f_lead(bit a2);  return a2 ? 15 : 11; endfunction
    function automatic int f_sweep(bit a2); return a2 ? 11 : 7;  endfunction
    function automatic int f_last(int sk, bit a2, bit pl);
        int e;
        e = sk + (a2 ? (pl ? 47 : 38) : (pl ? 134 : 108));
        return (e > 258) ? 258 : e;
    endfunction
    function automatic int f_slots(int sk, bit a2, bit pl);
        return f_lead(a2) + 13 + (f_last(sk, a2, pl) - sk) + f_sweep(a2);
    endfunction

    // phase code: 0 none, 1 shift, 2 window, 3 sweep
    task automatic cyc();
        bit s_sof, s_rst;
        int k, lead, w, ph, ln, vl, aph;
        string tag;
        @(posedge clk);
        s_sof = sof;
        s_rst = rst;
        #1;
        if (s_rst) begin
            m_active = 0;
        end else if (s_sof) begin
            m_active = 1; m_n = 0;
            m_skip = shift_cnt; m_af2 = af2_sel; m_pal = pal_sel;
        end else if (m_active) begin
            m_n++;
        end
        ph = 0; ln = 0; vl = 0; tag = "R1";
        if (m_active) begin
            k = m_n / L;
            lead = f_lead(m_af2);
            w = f_last(m_skip, m_af2, m_pal) - m_skip;
            tag = "R2";
            if (k < lead) ph = 0;
            else if (k < lead + 13) ph = 1;
            else if (k < lead + 13 + w) begin
                ph = 2;
                ln = m_skip + 1 + (k - lead - 13);
                vl = (ln >= m_skip + 3) ? 1 : 0;
                if (vl == 0) tag = "R3";
                else if (ln == m_skip + 3) tag = "R4";
                else if (ln == 258) tag = "R6";
                else tag = "R5";
            end else if (k < lead + 13 + w + f_sweep(m_af2)) begin
                ph = 3; tag = "R7";
            end else begin
                ph = 0; tag = "R7";
            end
        end
        aph = in_shift ? 1 : in_window ? 2 : in_sweep ? 3 : 0;
        chk($onehot0({in_shift, in_window, in_sweep}), "R10",
            int'(in_shift) + int'(in_window) + int'(in_sweep), 1);
        chk(aph == ph, tag, aph, ph);
        chk(int'(src_line) == ln, tag, int'(src_line), ln);
        chk(int'(line_valid) == vl, tag, int'(line_valid), vl);
        @(negedge clk);
    endtask

    task automatic start(input int sk, input bit a2, input bit pl);
        shift_cnt = 8'(sk); af2_sel = a2; pal_sel = pl;
        sof = 1'b1;
        cyc();
        sof = 1'b0;
    endtask

    task automatic run_frame(input int sk, input bit a2, input bit pl);
        start(sk, a2, pl);
        for (int c = 1; c < f_slots(sk, a2, pl) * L + 3; c++) cyc();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, sof ignored under reset
        sof = 1'b1;
        for (int c = 0; c < 4; c++) cyc();
        sof = 1'b0;
        rst = 1'b0;
        for (int c = 0; c < 6; c++) cyc();
        // R5, R4, R2, R7 directed: every mode at skip 0
        for (int m = 0; m < 4; m++) run_frame(0, m[1], m[0]);
        // R6 clip corners
        for (int m = 0; m < 4; m++) run_frame(255, m[1], m[0]);
        run_frame(150, 0, 0);
        run_frame(151, 0, 0);
        run_frame(124, 0, 1);
        run_frame(125, 0, 1);
        run_frame(220, 1, 0);
        run_frame(211, 1, 1);
        // R8: change settings after frame pulse; model keeps sampled values
        start(40, 0, 1);
        shift_cnt = 8'd200; af2_sel = 1'b1; pal_sel = 1'b0;
        for (int c = 1; c < f_slots(40, 0, 1) * L + 3; c++) cyc();
        // R9: restart in the middle of the window
        start(10, 1, 1);
        for (int c = 1; c < 33 * L + 2; c++) cyc();
        run_frame(77, 0, 0);
        // R9: restart during the sweep
        start(200, 0, 0);
        for (int c = 1; c < (11 + 13 + 58 + 3) * L; c++) cyc();
        run_frame(3, 1, 0);
        // random frames with fixed seed
        void'($urandom(32'h5eed_0af1));
        for (int f = 0; f < 24; f++) begin
            int sk;
            bit a2, pl;
            sk = $urandom_range(0, 255);
            a2 = $urandom_range(0, 1);
            pl = $urandom_range(0, 1);
            run_frame(sk, a2, pl);
        end
        // R1: reset mid-frame returns to idle
        start(30, 0, 0);
        for (int c = 0; c < 30 * L; c++) cyc();
        rst = 1'b1;
        for (int c = 0; c < 3; c++) cyc();
        rst = 1'b0;
        for (int c = 0; c < 8; c++) cyc();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule